// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block is the timekeeping core of a real-time clock. It keeps seconds, minutes, hours, day of month, weekday, month and a two-digit year (standing for 2000 to 2099) in packed BCD. It advances them by one second each time a parameterized number of sub-second ticks has been counted. Carries ripple through the whole calendar in the same clock edge, including month lengths and leap years.

Software reaches the time fields and one control register over a simple register bus. Writes are synchronous and reads are combinational. Software can freeze counting while it loads a new time, select a 12-hour display format, and command a soft reset with a key pattern. Bit 7 of the seconds register is a sticky flag that marks the stored time as invalid. It is set at power-on, on soft reset, and whenever the `oscLost` input reports a loss of oscillation.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the registers read: control (0x0) = 0x00, seconds (0x2) = 0x80, minutes (0x3) = 0x00, hours (0x4) = 0x00, day of month (0x5) = 0x01, weekday (0x6) = 0x00, month (0x7) = 0x01, year (0x8) = 0x00.
- R2: While running, seconds advance by one in BCD (0x09 becomes 0x10) on the SUB_PER_SEC-th `subTick` pulse. Registers never change on a cycle with neither `subTick` nor a bus write.
- R3: Control bit 5 = 1 stops counting. Clearing it restarts the sub-second count from zero, so the first increment needs a full SUB_PER_SEC pulses.
- R4: Seconds 0x59 roll to 0x00 and carry into minutes. Minutes 0x59 roll to 0x00 and carry into hours.
- R5: In 24-hour mode (control bit 2 = 0), hours 0x23 roll to 0x00 and advance the day. On that day advance the weekday (binary 0 to 6) rolls from 6 to 0.
- R6: In 12-hour mode (control bit 2 = 1), hours hold BCD 1 to 12 in bits 4:0 with bit 5 as PM. 11 becomes 12 with the PM bit inverted. 12 becomes 01 with PM kept. The day advances only when 11 PM becomes 12 AM.
- R7: The day of month rolls to 0x01 and the month advances after day 0x30 in April, June, September and November, and after 0x31 in the other long months. February ends at 0x28, or at 0x29 when the year is divisible by 4.
- R8: Month 0x12 rolls to 0x01 and advances the year in BCD. Year 0x99 rolls to 0x00.
- R9: Seconds bit 7 is a sticky invalid flag. It is set by reset and by `oscLost` = 1. Writing 0 in bit 7 clears it, writing 1 leaves it unchanged, and `oscLost` wins over a clearing write in the same cycle.
- R10: A write to control (0x0) with bits 6, 4 and 3 all set (value & 0x58 == 0x58) returns every register to its R1 value. A write with only some of those bits set does not.
- R11: Fields read back masked: minutes 7 bits, hours and day 6 bits, weekday 3 bits, month 5 bits, year 8 bits. Control keeps only bits 5, 2 and 1. Addresses 0x1 and 0x9 to 0xF read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| subTick | input | 1 | One-cycle sub-second tick from an external prescaler |
| oscLost | input | 1 | High while loss of oscillation is reported |
| busAddr | input | 4 | Register address for reads and writes |
| busWr | input | 1 | Write strobe, captured at the rising clock edge |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data for `busAddr` |

## Verification
A bus write, or the `subTick` pulse that completes a second, takes effect at the next rising edge. Read data follows `busAddr` in the same cycle. The driver therefore sets the address half a cycle before an edge and queues the expected value. The monitor samples 5 ns after that edge, while `subTick` and `busWr` are held low, so no register can move between the edge and the sample. Each calendar case is loaded while counting is stopped and then released, which zeroes the sub-second count. This makes the rollover land exactly on the fourth pulse.

// File: rtl/bcd_calendar_pkg.sv
package bcd_calendar_pkg;

  localparam int ADDR_W = 4;
  localparam int NUM_TIME_REGS = 7;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_SEC  = 4'h2;
  localparam logic [ADDR_W-1:0] ADDR_MIN  = 4'h3;
  localparam logic [ADDR_W-1:0] ADDR_HR   = 4'h4;
  localparam logic [ADDR_W-1:0] ADDR_DOM  = 4'h5;
  localparam logic [ADDR_W-1:0] ADDR_WDAY = 4'h6;
  localparam logic [ADDR_W-1:0] ADDR_MON  = 4'h7;
  localparam logic [ADDR_W-1:0] ADDR_YR   = 4'h8;

  localparam int STOP_BIT   = 5;
  localparam int MODE12_BIT = 2;
  localparam int CORR_BIT   = 1;
  localparam logic [7:0] SOFT_RESET_KEY = 8'h58;

  typedef struct packed {
    logic       oscFlag;
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hr;
    logic [5:0] dom;
    logic [2:0] wday;
    logic [4:0] mon;
    logic [7:0] yr;
  } calTime_t;

  localparam calTime_t CAL_RESET = '{oscFlag: 1'b1, sec: 7'h00, min: 7'h00,
                                     hr: 6'h00, dom: 6'h01, wday: 3'd0,
                                     mon: 5'h01, yr: 8'h00};

  typedef struct packed {
    logic                     advance;
    logic                     clear;
    logic                     mode12;
    logic [NUM_TIME_REGS-1:0] timeWr;
    logic [7:0]               wrData;
  } calStrobe_t;

  function automatic logic [7:0] bcdInc8(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else r = v + 8'd1;
    return r;
  endfunction

  function automatic logic isLeapYear(input logic [7:0] yr);
    logic [3:0] ones;
    ones = yr[3:0];
    if (yr[4]) return (ones == 4'd2) || (ones == 4'd6);
    return (ones == 4'd0) || (ones == 4'd4) || (ones == 4'd8);
  endfunction

  function automatic logic [5:0] lastDayOf(input logic [4:0] mon, input logic [7:0] yr);
    logic [5:0] d;
    case (mon)
      5'h02: d = isLeapYear(yr) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: d = 6'h30;
      default: d = 6'h31;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/bcd_calendar_ctrl.sv
module bcd_calendar_ctrl
  import bcd_calendar_pkg::*;
#(
  parameter int SUB_PER_SEC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              subTick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [7:0]        busWrData,
  output calStrobe_t        strobe,
  output logic [7:0]        ctrlReg
);

  localparam int PW = (SUB_PER_SEC > 1) ? $clog2(SUB_PER_SEC) : 1;
  localparam logic [PW-1:0] PRESC_LAST = PW'(SUB_PER_SEC - 1);

  logic stopBit, mode12, corrIe;
  logic [PW-1:0] presc;
  logic ctrlWr, softHit;
  logic [NUM_TIME_REGS-1:0] timeWrVec;

  assign ctrlWr  = busWr && (busAddr == ADDR_CTRL);
  assign softHit = ctrlWr && ((busWrData & SOFT_RESET_KEY) == SOFT_RESET_KEY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopBit <= 1'b0;
      mode12  <= 1'b0;
      corrIe  <= 1'b0;
    end else if (softHit) begin
      stopBit <= 1'b0;
      mode12  <= 1'b0;
      corrIe  <= 1'b0;
    end else if (ctrlWr) begin
      stopBit <= busWrData[STOP_BIT];
      mode12  <= busWrData[MODE12_BIT];
      corrIe  <= busWrData[CORR_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) presc <= '0;
    else if (softHit || stopBit) presc <= '0;
    else if (subTick) presc <= (presc == PRESC_LAST) ? '0 : presc + 1'b1;
  end

  for (genvar i = 0; i < NUM_TIME_REGS; i++) begin : g_wrDecode
    assign timeWrVec[i] = busWr && (busAddr == ADDR_W'(ADDR_SEC + i));
  end

  always_comb begin
    strobe.advance = subTick && !stopBit && (presc == PRESC_LAST);
    strobe.clear   = softHit;
    strobe.mode12  = mode12;
    strobe.timeWr  = timeWrVec;
    strobe.wrData  = busWrData;
  end

  always_comb begin
    ctrlReg = 8'h00;
    ctrlReg[STOP_BIT]   = stopBit;
    ctrlReg[MODE12_BIT] = mode12;
    ctrlReg[CORR_BIT]   = corrIe;
  end

endmodule

// File: rtl/bcd_calendar_datapath.sv
module bcd_calendar_datapath
  import bcd_calendar_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       oscLost,
  input  calStrobe_t strobe,
  output calTime_t   timeNow
);

  calTime_t cur, nxt;
  logic cMin, cHr, cDay, cMon, cYr, dayFromHr;
  logic [7:0] secInc, minInc, hr24Inc, hr12Inc, domInc, monInc, yrInc;
  logic [5:0] hrNext;

  assign timeNow = cur;

  always_comb begin
    secInc  = bcdInc8({1'b0, cur.sec});
    minInc  = bcdInc8({1'b0, cur.min});
    hr24Inc = bcdInc8({2'b0, cur.hr});
    hr12Inc = bcdInc8({3'b0, cur.hr[4:0]});
    domInc  = bcdInc8({2'b0, cur.dom});
    monInc  = bcdInc8({3'b0, cur.mon});
    yrInc   = bcdInc8(cur.yr);

    // hour step and whether it crosses midnight
    if (strobe.mode12) begin
      if (cur.hr[4:0] == 5'h12) begin
        hrNext    = {cur.hr[5], 5'h01};
        dayFromHr = 1'b0;
      end else if (cur.hr[4:0] == 5'h11) begin
        hrNext    = {~cur.hr[5], 5'h12};
        dayFromHr = cur.hr[5];
      end else begin
        hrNext    = {cur.hr[5], hr12Inc[4:0]};
        dayFromHr = 1'b0;
      end
    end else if (cur.hr == 6'h23) begin
      hrNext    = 6'h00;
      dayFromHr = 1'b1;
    end else begin
      hrNext    = hr24Inc[5:0];
      dayFromHr = 1'b0;
    end

    cMin = strobe.advance && (cur.sec == 7'h59);
    cHr  = cMin && (cur.min == 7'h59);
    cDay = cHr && dayFromHr;
    cMon = cDay && (cur.dom == lastDayOf(cur.mon, cur.yr));
    cYr  = cMon && (cur.mon == 5'h12);

    nxt = cur;
    if (strobe.advance) nxt.sec = cMin ? 7'h00 : secInc[6:0];
    if (cMin) nxt.min = cHr ? 7'h00 : minInc[6:0];
    if (cHr) nxt.hr = hrNext;
    if (cDay) begin
      nxt.wday = (cur.wday == 3'd6) ? 3'd0 : cur.wday + 3'd1;
      nxt.dom  = cMon ? 6'h01 : domInc[5:0];
    end
    if (cMon) nxt.mon = cYr ? 5'h01 : monInc[4:0];
    if (cYr) nxt.yr = (cur.yr == 8'h99) ? 8'h00 : yrInc;

    // bus writes override the count for the written field
    if (strobe.timeWr[0]) begin
      nxt.sec     = strobe.wrData[6:0];
      nxt.oscFlag = cur.oscFlag & strobe.wrData[7];
    end
    if (strobe.timeWr[1]) nxt.min  = strobe.wrData[6:0];
    if (strobe.timeWr[2]) nxt.hr   = strobe.wrData[5:0];
    if (strobe.timeWr[3]) nxt.dom  = strobe.wrData[5:0];
    if (strobe.timeWr[4]) nxt.wday = strobe.wrData[2:0];
    if (strobe.timeWr[5]) nxt.mon  = strobe.wrData[4:0];
    if (strobe.timeWr[6]) nxt.yr   = strobe.wrData;

    if (oscLost) nxt.oscFlag = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cur <= CAL_RESET;
    else if (strobe.clear) cur <= CAL_RESET;
    else cur <= nxt;
  end

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import bcd_calendar_pkg::*;
#(
  parameter int SUB_PER_SEC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              subTick,
  input  logic              oscLost,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData
);

  calStrobe_t strobe;
  calTime_t   timeNow;
  logic [7:0] ctrlReg;

  bcd_calendar_ctrl #(.SUB_PER_SEC(SUB_PER_SEC)) ctrl_i (
    .clk(clk), .rstN(rstN), .subTick(subTick), .busAddr(busAddr),
    .busWr(busWr), .busWrData(busWrData), .strobe(strobe), .ctrlReg(ctrlReg)
  );

  bcd_calendar_datapath dp_i (
    .clk(clk), .rstN(rstN), .oscLost(oscLost), .strobe(strobe), .timeNow(timeNow)
  );

  always_comb begin
    case (busAddr)
      ADDR_CTRL: busRdData = ctrlReg;
      ADDR_SEC:  busRdData = {timeNow.oscFlag, timeNow.sec};
      ADDR_MIN:  busRdData = {1'b0, timeNow.min};
      ADDR_HR:   busRdData = {2'b0, timeNow.hr};
      ADDR_DOM:  busRdData = {2'b0, timeNow.dom};
      ADDR_WDAY: busRdData = {5'b0, timeNow.wday};
      ADDR_MON:  busRdData = {3'b0, timeNow.mon};
      ADDR_YR:   busRdData = timeNow.yr;
      default:   busRdData = 8'h00;
    endcase
  end

endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk
  import bcd_calendar_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              subTick,
  input logic              oscLost,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic [7:0]        busWrData,
  input calStrobe_t        strobe,
  input calTime_t          timeNow,
  input logic [7:0]        ctrlReg
);

  // R9
  osc_lost_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    oscLost |=> timeNow.oscFlag);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!subTick && !busWr) |=> ($stable(timeNow.sec) && $stable(timeNow.min) &&
                              $stable(timeNow.hr) && $stable(timeNow.dom) &&
                              $stable(timeNow.mon) && $stable(timeNow.yr)));

  // R3
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[STOP_BIT] && !busWr) |=> ($stable(timeNow.sec) && $stable(timeNow.min)));

  // R4
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && timeNow.sec == 7'h59 && !busWr) |=> (timeNow.sec == 7'h00));

  // R5
  midnight_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.mode12 && timeNow.sec == 7'h59 && timeNow.min == 7'h59 &&
     timeNow.hr == 6'h23 && !busWr) |=> (timeNow.hr == 6'h00));

  // R6
  noon_no_day_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && strobe.mode12 && timeNow.sec == 7'h59 && timeNow.min == 7'h59 &&
     timeNow.hr == 6'h11 && !busWr) |=> (timeNow.hr == 6'h32 && $stable(timeNow.dom)));

  // R10
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_CTRL && (busWrData & SOFT_RESET_KEY) == SOFT_RESET_KEY)
    |=> (ctrlReg == 8'h00 && timeNow.oscFlag && timeNow.dom == 6'h01 &&
         timeNow.mon == 5'h01 && timeNow.yr == 8'h00));

endmodule

bind bcd_calendar bcd_calendar_chk chk_i (
  .clk(clk), .rstN(rstN), .subTick(subTick), .oscLost(oscLost),
  .busAddr(busAddr), .busWr(busWr), .busWrData(busWrData),
  .strobe(strobe), .timeNow(timeNow), .ctrlReg(ctrlReg)
);

// File: tb/bcd_calendar_tb_top.sv
module bcd_calendar_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int SUB = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic subTick = 1'b0;
  logic oscLost = 1'b0;
  logic [3:0] busAddr = 4'h0;
  logic busWr = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [3:0] addr;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  item_t it;

  bcd_calendar #(.SUB_PER_SEC(SUB)) dut_i (
    .clk(clk), .rstN(rstN), .subTick(subTick), .oscLost(oscLost),
    .busAddr(busAddr), .busWr(busWr), .busWrData(busWrData), .busRdData(busRdData)
  );

  always #10 clk = ~clk;

  // monitor: compare 5 ns after each rising edge
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      it = q.pop_front();
      testsRun++;
      if (busRdData !== it.exp) begin
        testsFailed++;
        $display("FAIL %s addr=%0h actual=%02h expected=%02h", it.tag, it.addr, busRdData, it.exp);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWr = 1'b1; busWrData = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); subTick = 1'b1;
      @(negedge clk); subTick = 1'b0;
    end
  endtask

  task automatic chk(input logic [3:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    busAddr = a;
    q.push_back('{addr: a, exp: e, tag: t});
    @(negedge clk);
  endtask

  task automatic loadTime(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                          input logic [7:0] dm, input logic [7:0] wd, input logic [7:0] mo,
                          input logic [7:0] y, input logic [7:0] ctl);
    wr(4'h0, 8'h20 | ctl);
    wr(4'h2, s); wr(4'h3, m); wr(4'h4, h); wr(4'h5, dm);
    wr(4'h6, wd); wr(4'h7, mo); wr(4'h8, y);
    wr(4'h0, ctl);
  endtask

  task automatic dayRoll(input logic [7:0] dm, input logic [7:0] mo, input logic [7:0] y,
                         input logic [7:0] expDm, input logic [7:0] expMo, input string t);
    loadTime(8'h59, 8'h59, 8'h23, dm, 8'h00, mo, y, 8'h00);
    ticks(SUB);
    chk(4'h5, expDm, t);
    chk(4'h7, expMo, t);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    chk(4'h0, 8'h00, "R1 ctrl");
    chk(4'h2, 8'h80, "R1 sec");
    chk(4'h3, 8'h00, "R1 min");
    chk(4'h4, 8'h00, "R1 hr");
    chk(4'h5, 8'h01, "R1 dom");
    chk(4'h6, 8'h00, "R1 wday");
    chk(4'h7, 8'h01, "R1 mon");
    chk(4'h8, 8'h00, "R1 yr");

    // R9 invalid flag
    wr(4'h2, 8'h00); chk(4'h2, 8'h00, "R9 clear by write 0");
    wr(4'h2, 8'h85); chk(4'h2, 8'h05, "R9 write 1 does not set");
    @(negedge clk); oscLost = 1'b1;
    @(negedge clk); oscLost = 1'b0;
    chk(4'h2, 8'h85, "R9 oscLost sets");
    @(negedge clk); oscLost = 1'b1;
    wr(4'h2, 8'h05);
    oscLost = 1'b0;
    chk(4'h2, 8'h85, "R9 oscLost beats clear");
    wr(4'h2, 8'h00); chk(4'h2, 8'h00, "R9 cleared again");

    // R11 masking and unmapped reads
    wr(4'h3, 8'hFF); chk(4'h3, 8'h7F, "R11 min mask");
    wr(4'h4, 8'hFF); chk(4'h4, 8'h3F, "R11 hr mask");
    wr(4'h6, 8'hFF); chk(4'h6, 8'h07, "R11 wday mask");
    wr(4'h7, 8'hFF); chk(4'h7, 8'h1F, "R11 mon mask");
    wr(4'h0, 8'hA7); chk(4'h0, 8'h26, "R11 ctrl keeps 5,2,1");
    chk(4'h1, 8'h00, "R11 addr 1 reads zero");
    chk(4'hF, 8'h00, "R11 addr F reads zero");
    wr(4'h0, 8'h00);

    // R2 prescaled second and BCD step
    wr(4'h2, 8'h08);
    ticks(SUB - 1); chk(4'h2, 8'h08, "R2 not yet a second");
    ticks(1);       chk(4'h2, 8'h09, "R2 one second");
    ticks(SUB);     chk(4'h2, 8'h10, "R2 BCD carry 09->10");

    // R3 stop and prescaler restart
    ticks(2);
    wr(4'h0, 8'h20);
    ticks(2 * SUB); chk(4'h2, 8'h10, "R3 frozen while stopped");
    wr(4'h0, 8'h00);
    ticks(SUB - 1); chk(4'h2, 8'h10, "R3 prescaler restarted");
    ticks(1);       chk(4'h2, 8'h11, "R3 full second after release");

    // R4 sec and minute carries
    loadTime(8'h59, 8'h59, 8'h05, 8'h10, 8'h03, 8'h05, 8'h24, 8'h00);
    ticks(SUB);
    chk(4'h2, 8'h00, "R4 sec wrap");
    chk(4'h3, 8'h00, "R4 min wrap");
    chk(4'h4, 8'h06, "R4 hour step");
    chk(4'h5, 8'h10, "R4 day kept");

    // R5 midnight in 24-hour mode
    loadTime(8'h59, 8'h59, 8'h23, 8'h10, 8'h06, 8'h05, 8'h24, 8'h00);
    ticks(SUB);
    chk(4'h4, 8'h00, "R5 hour 23->00");
    chk(4'h6, 8'h00, "R5 weekday 6->0");
    chk(4'h5, 8'h11, "R5 day step");

    // R7 month lengths and leap years
    dayRoll(8'h30, 8'h04, 8'h24, 8'h01, 8'h05, "R7 April 30");
    dayRoll(8'h30, 8'h05, 8'h24, 8'h31, 8'h05, "R7 May 30");
    dayRoll(8'h31, 8'h07, 8'h24, 8'h01, 8'h08, "R7 July 31");
    dayRoll(8'h30, 8'h11, 8'h24, 8'h01, 8'h12, "R7 November 30");
    dayRoll(8'h28, 8'h02, 8'h23, 8'h01, 8'h03, "R7 Feb 28 common");
    dayRoll(8'h28, 8'h02, 8'h24, 8'h29, 8'h02, "R7 Feb 28 leap");
    dayRoll(8'h29, 8'h02, 8'h24, 8'h01, 8'h03, "R7 Feb 29 leap");
    dayRoll(8'h28, 8'h02, 8'h00, 8'h29, 8'h02, "R7 year 00 leap");
    dayRoll(8'h28, 8'h02, 8'h10, 8'h01, 8'h03, "R7 year 10 common");
    dayRoll(8'h28, 8'h02, 8'h12, 8'h29, 8'h02, "R7 year 12 leap");

    // R8 month and year rollover
    dayRoll(8'h30, 8'h09, 8'h24, 8'h01, 8'h10, "R8 month BCD 09->10");
    dayRoll(8'h31, 8'h12, 8'h23, 8'h01, 8'h01, "R8 December end");
    chk(4'h8, 8'h24, "R8 year step");
    dayRoll(8'h31, 8'h12, 8'h99, 8'h01, 8'h01, "R8 century end");
    chk(4'h8, 8'h00, "R8 year 99->00");

    // R6 12-hour mode
    loadTime(8'h59, 8'h59, 8'h11, 8'h15, 8'h02, 8'h03, 8'h24, 8'h04);
    ticks(SUB);
    chk(4'h0, 8'h04, "R6 mode bit");
    chk(4'h4, 8'h32, "R6 11AM->12PM");
    chk(4'h5, 8'h15, "R6 noon keeps day");
    loadTime(8'h59, 8'h59, 8'h12, 8'h15, 8'h02, 8'h03, 8'h24, 8'h04);
    ticks(SUB);
    chk(4'h4, 8'h01, "R6 12AM->01AM");
    loadTime(8'h59, 8'h59, 8'h32, 8'h15, 8'h02, 8'h03, 8'h24, 8'h04);
    ticks(SUB);
    chk(4'h4, 8'h21, "R6 12PM->01PM");
    loadTime(8'h59, 8'h59, 8'h31, 8'h15, 8'h02, 8'h03, 8'h24, 8'h04);
    ticks(SUB);
    chk(4'h4, 8'h12, "R6 11PM->12AM");
    chk(4'h5, 8'h16, "R6 midnight day step");
    chk(4'h6, 8'h03, "R6 midnight weekday step");

    // R10 soft reset
    loadTime(8'h30, 8'h45, 8'h10, 8'h20, 8'h04, 8'h06, 8'h50, 8'h06);
    wr(4'h0, 8'h18);
    chk(4'h0, 8'h00, "R10 partial key stores ctrl");
    chk(4'h3, 8'h45, "R10 partial key no reset");
    chk(4'h2, 8'h30, "R10 partial key flag clear");
    wr(4'h0, 8'h06);
    wr(4'h0, 8'h58);
    chk(4'h0, 8'h00, "R10 ctrl");
    chk(4'h2, 8'h80, "R10 sec and flag");
    chk(4'h3, 8'h00, "R10 min");
    chk(4'h4, 8'h00, "R10 hr");
    chk(4'h5, 8'h01, "R10 dom");
    chk(4'h6, 8'h00, "R10 wday");
    chk(4'h7, 8'h01, "R10 mon");
    chk(4'h8, 8'h00, "R10 yr");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule